// File: doc/BRIEF.md
# Tuner Control Register Slave on a Two-Wire Bus

This block is a two-wire serial bus target that holds a bank of sixteen 8-bit control registers for a radio tuner front end. It oversamples the clock and data lines with the system clock and finds START and STOP conditions. It answers one of three 7-bit device addresses, picked by a 2-bit select input. Every register drives a parallel output bus, so the tuner logic always sees the latest values without polling.

A transfer carries no register index byte. The first data byte after the address byte is written to, or read from, register 0. The internal pointer then steps to the next register after every data byte, in both directions. A bus-enable input gates the slave. While it is low, the slave ignores all line activity, so other traffic on the same wires can run faster than this slave supports. The block never stretches the clock. Its register outputs are plain levels with no handshake: each write is taken at once, so there is no back-pressure.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits match the code picked by `addr_sel`. Select 0 matches 7'b1100001, select 1 matches 7'b1100000, select 2 matches 7'b1100010, and select 3 matches nothing. After an address that does not match, SDA stays released until the next START and no register changes.
- R2: Bit 0 of the address byte is the direction bit, where 0 means write. In a write, the first data byte lands in register 0 and each later byte lands in the next register. The slave acknowledges every data byte by holding SDA low during the ninth clock.
- R3: When the direction bit is 1, the slave sends register 0 first and then the following registers, MSB first, one bit for each SCL period. A master ACK makes it send the next register. A master NACK makes it release SDA and wait for STOP or START.
- R4: After register 15, the pointer wraps to register 0, for both reads and writes.
- R5: While `bus_en` is low, the slave never drives SDA and no register changes, whatever happens on SCL and SDA.
- R6: If `bus_en` goes low during a transfer, the slave returns to idle. It ignores the rest of that transfer, even after `bus_en` goes high again, until the next START.
- R7: A repeated START resets the pointer to register 0 and starts address matching again.
- R8: After reset all registers read 0 and SDA is released. A STOP returns the slave to idle.
- R9: Register k appears on `regs_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | High lets the slave take part in bus traffic |
| addr_sel | input | 2 | Picks which device address the slave answers |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| regs_o | output | 128 | All sixteen registers, register k in bits 8k+7:8k |

## Verification
A pointer that is wrong shows up on `regs_o` within a few system clocks after the falling SCL edge that ends a data byte: the byte lands in the wrong 8-bit lane. A transfer state that is wrong shows up at the ninth clock of the same byte as a missing or unexpected ACK, or as a wrong data bit on SDA during the very next SCL high phase of a read. A gate that fails to act shows up as SDA being pulled low, or as a register changing, while `bus_en` is low. That error is visible within one byte time.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } link_state_t;

  // Returns {valid, 7-bit address} for a select code.
  function automatic logic [7:0] dev_code_for(input logic [1:0] sel);
    logic [7:0] r;
    case (sel)
      2'd0:    r = {1'b1, 7'b1100001};
      2'd1:    r = {1'b1, 7'b1100000};
      2'd2:    r = {1'b1, 7'b1100010};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[TOP];
      sda_q <= sda_pipe[TOP];
    end
  end

  assign scl_now   = scl_pipe[TOP];
  assign sda_lvl   = sda_pipe[TOP];
  assign scl_rise  = !scl_q && scl_now;
  assign scl_fall  = scl_q && !scl_now;
  assign start_det = scl_q && scl_now && sda_q && !sda_lvl;
  assign stop_det  = scl_q && scl_now && !sda_q && sda_lvl;

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PW-1:0]      widx,
  input  logic [DW-1:0]      wdata,
  input  logic [PW-1:0]      ridx,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] regs_flat
);

  logic [DW-1:0] mem [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (we && widx == PW'(g))
          mem[g] <= wdata;
      end
      assign regs_flat[g*DW +: DW] = mem[g];
    end
  endgenerate

  assign rdata = mem[ridx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_flat[$past(widx)*DW +: DW] == $past(wdata)); // R2
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_flat)); // R5

endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
  import tuner_i2c_pkg::*;
#(
  parameter int NREG = 16,
  localparam int PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic [1:0]    addr_sel,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_idx,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  link_state_t   state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_next;
  logic          rw;
  logic          mack;
  logic [7:0]    dev;
  logic          addr_hit;

  assign dev      = dev_code_for(addr_sel);
  assign addr_hit = dev[7] && (shreg[7:1] == dev[6:0]);
  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign rd_idx   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!bus_en) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= shreg;
                ptr     <= ptr_next;
                sda_oe  <= 1'b1;
                state   <= ST_WACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                shreg  <= rd_data;
                ptr    <= ptr_next;
                sda_oe <= !rd_data[7];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= !shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= !sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                bitcnt <= '0;
                shreg  <= rd_data;
                ptr    <= ptr_next;
                sda_oe <= !rd_data[7];
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (!sda_oe && state == ST_IDLE)); // R5
  AST_START_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && start_det) |=> (ptr == '0 && state == ST_ADDR)); // R7
  AST_OE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {ST_ADDR_ACK, ST_WACK, ST_RDATA})); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == LAST) |-> ptr == '0); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && stop_det && !start_det) |=> state == ST_IDLE); // R8

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs #(
  parameter int NREG      = 16,
  parameter int SYNC_FFS  = 2,
  localparam int DW       = 8,
  localparam int PW       = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic [1:0]         addr_sel,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);

  logic          sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [PW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  i2c_line_sampler #(.STAGES(SYNC_FFS)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_xfer_engine #(.NREG(NREG)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .addr_sel  (addr_sel),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  tuner_reg_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_en),
    .widx      (wr_idx),
    .wdata     (wr_data),
    .ridx      (rd_idx),
    .rdata     (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: tb/sim_tuner_i2c_regs.sv
`timescale 1ns/1ps
module sim_tuner_i2c_regs;

  localparam int NREG = 16;
  localparam int Q    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b1;
  logic [1:0]        sel = 2'd0;
  logic              scl = 1'b1;
  logic              sda_m = 1'b1;
  logic              sda_oe;
  logic              sda_line;
  logic [NREG*8-1:0] regs;

  logic [7:0] exp_r [NREG];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit oe_while_off = 1'b0;
  logic en_prev = 1'b1;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  tuner_i2c_regs u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .addr_sel (sel),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .regs_o   (regs)
  );

  always @(negedge clk) begin
    if (!bus_en && !en_prev && sda_oe) oe_while_off = 1'b1;
    en_prev = bus_en;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == exp_r[i], tag, regs[i*8 +: 8], exp_r[i]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!master_ack);
  endtask

  // R1 R2: write n bytes starting at register 0
  task automatic t_write(input logic [1:0] s, input logic [7:0] addr, input int n,
                         input logic [7:0] base, input string tag);
    logic ack;
    int p = 0;
    sel = s;
    bus_start();
    send_byte(addr, ack);
    chk(ack, {tag, " address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = base + 8'(i * 13);
      send_byte(d, ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      exp_r[p] = d;
      p = (p + 1) % NREG;
    end
    bus_stop();
    tick(Q);
    check_regs(tag);
  endtask

  // R3: read n bytes from register 0, NACK on the last
  task automatic t_read(input int n);
    logic ack;
    logic [7:0] d;
    sel = 2'd0;
    bus_start();
    send_byte(8'hC3, ack);
    chk(ack, "R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == exp_r[i % NREG], "R3 read data", d, exp_r[i % NREG]);
    end
    chk(sda_oe == 1'b0, "R3 released after NACK", sda_oe, 0);
    bus_stop();
    tick(Q);
  endtask

  // R1: address that does not match is ignored
  task automatic t_wrong_addr(input logic [1:0] s, input logic [7:0] addr, input string tag);
    logic ack;
    sel = s;
    bus_start();
    send_byte(addr, ack);
    chk(!ack, {tag, " no address ack"}, ack, 0);
    send_byte(8'h5A, ack);
    chk(!ack, {tag, " no data ack"}, ack, 0);
    bus_stop();
    tick(Q);
    check_regs(tag);
  endtask

  // R5: disabled slave ignores a full transfer
  task automatic t_disabled();
    logic ack;
    sel = 2'd0;
    bus_en = 1'b0;
    oe_while_off = 1'b0;
    bus_start();
    send_byte(8'hC2, ack);
    chk(!ack, "R5 no ack while disabled", ack, 0);
    send_byte(8'hE7, ack);
    send_byte(8'h18, ack);
    bus_stop();
    tick(Q);
    chk(!oe_while_off, "R5 SDA never driven", oe_while_off, 0);
    check_regs("R5 registers untouched");
    bus_en = 1'b1;
    tick(Q);
  endtask

  // R6: enable drop mid-address aborts the transfer
  task automatic t_mid_drop();
    logic ack;
    logic [7:0] a = 8'hC2;
    sel = 2'd0;
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(a[i]);
    bus_en = 1'b0;
    tick(3);
    bus_en = 1'b1;
    for (int i = 3; i >= 0; i--) put_bit(a[i]);
    get_bit(ack);
    chk(ack == 1'b1, "R6 no ack after enable glitch", !ack, 0);
    send_byte(8'h99, ack);
    chk(!ack, "R6 data ignored", ack, 0);
    bus_stop();
    tick(Q);
    check_regs("R6 registers untouched");
  endtask

  // R7: repeated START resets pointer
  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    sel = 2'd0;
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    exp_r[0] = 8'h11; exp_r[1] = 8'h22;
    bus_start();
    send_byte(8'hC2, ack);
    chk(ack, "R7 ack after repeated START", ack, 1);
    send_byte(8'h33, ack);
    exp_r[0] = 8'h33;
    tick(Q);
    check_regs("R7 write restarts at register 0");
    bus_start();
    send_byte(8'hC3, ack);
    recv_byte(1'b0, d);
    chk(d == 8'h33, "R7 read restarts at register 0", d, 8'h33);
    bus_stop();
    tick(Q);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R8 reset SDA released", sda_oe, 0);
    check_regs("R8 reset registers zero");

    t_write(2'd0, 8'hC2, 3, 8'hA5, "R2 R9 write sel0");
    t_read(3);
    t_wrong_addr(2'd0, 8'hC0, "R1 wrong address sel0");
    t_write(2'd1, 8'hC0, 2, 8'h3C, "R1 write sel1");
    t_write(2'd2, 8'hC4, 2, 8'h71, "R1 write sel2");
    t_wrong_addr(2'd3, 8'hC2, "R1 select 3 matches none");
    t_write(2'd0, 8'hC2, 18, 8'h07, "R4 write wraps");
    t_read(18);
    t_disabled();
    t_mid_drop();
    t_write(2'd0, 8'hC2, 1, 8'hEE, "R6 next START works");
    t_restart();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule